// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex 8-bit synchronous serial engine. It drives a shift clock on its own output and moves data over one data line. The pad-level tristate is split into an output value, an output enable and an input. Software talks to it through two byte-wide locations. One is a control word that holds the mode selection, a speed selector, a receive enable, two ninth-bit fields and the transmit-done and receive-done flags. The other is a data location: a write there goes to a transmit shift register, and a read returns a separate receive buffer.

A write to the data location while the port is idle starts a transmission. Eight bits go out LSB first. While the receive enable is set and the receive-done flag is clear, the idle port starts a reception and shifts eight bits in, LSB first. Each bit lasts 12 clocks, or 4 clocks when the speed selector is set. The shift clock is low for the first half of every bit period and high for the second half. When no transfer is running, the shift clock rests high and the data line is released.

Top module: `sser_mode0`

## Requirements
- R1: After reset the control word and the receive buffer read as 0, sclk_o is 1 and sd_oe_o is 0.
- R2: A transfer starts only when control bits 7 and 6 are both 0. With any other value, data writes and the receive enable start nothing.
- R3: A bit period is 12 clocks when control bit 5 is 0 and 4 clocks when it is 1. sclk_o is low for the first half of each period and high for the second half.
- R4: A write to address 1 while idle starts a transmission. sd_oe_o is 1 for the whole transfer, and sd_o carries bit k of the written byte (LSB first) throughout period k.
- R5: Control bit 1 (transmit done) becomes 1 at the edge that ends the 8th period, counted from the starting write edge. It stays 1 until software writes it to 0.
- R6: With control bit 4 (receive enable) at 1, control bit 0 (receive done) at 0 and the port idle, a reception starts on the edge after the control write. sd_oe_o stays 0 throughout the reception.
- R7: A received bit is captured on the clock edge at which sclk_o rises. Bits fill the byte LSB first, and the completed byte reads back at address 1.
- R8: Control bit 0 becomes 1 at the edge that ends the 8th period of a reception. While it stays 1, no new reception starts.
- R9: A write to address 1 during a transfer has no effect on that transfer and does not start another one.
- R10: Control bits 3 and 2 change only by software writes. Hardware leaves them unchanged through a transfer.
- R11: Writing address 1 does not change the value read from address 1, which stays the last received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects the control word, 1 the data location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| sclk_o | output | 1 | Shift clock |
| sd_o | output | 1 | Serial data out value |
| sd_oe_o | output | 1 | Serial data out enable |
| sd_i | input | 1 | Serial data in |

## Verification
The transmit-done flag is due exactly 8·P edges after the edge that accepts the data write, where P is 12 or 4. The receive-done flag is due 8·P+1 edges after the control write, because the start decision reads the registered control word. The bench counts edges from the starting write, samples at the falling clock edge, and checks each flag both in the cycle before it is due and in the cycle it is due. Serial bits are matched to shift clock edges seen at the ports. Transmit data is taken at each sclk_o rise, and receive data is driven at each sclk_o fall, half a period before the design captures it.

// File: rtl/sser_pkg.sv
package sser_pkg;
  localparam int BIT_M0     = 7;
  localparam int BIT_M1     = 6;
  localparam int BIT_FAST   = 5;
  localparam int BIT_RXEN   = 4;
  localparam int BIT_TXDONE = 1;
  localparam int BIT_RXDONE = 0;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
endpackage

// File: rtl/sser_bit_timer.sv
module sser_bit_timer #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  input  logic run_i,
  output logic sclk_low_o,
  output logic sample_o,
  output logic bit_end_o
);
  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_HLF  = CNT_W'(SLOW_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] FAST_HLF  = CNT_W'(FAST_DIV / 2 - 1);

  logic             fast_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt, half_cnt;

  assign last_cnt = fast_q ? FAST_LAST : SLOW_LAST;
  assign half_cnt = fast_q ? FAST_HLF : SLOW_HLF;

  // speed is latched per transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      fast_q <= fast_i;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
    end
  end

  assign sclk_low_o = run_i && (cnt_q <= half_cnt);
  assign sample_o   = run_i && (cnt_q == half_cnt);
  assign bit_end_o  = run_i && (cnt_q == last_cnt);
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_tx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              advance_i,
  input  logic              sample_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              last_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      tx_q  <= '0;
    end else if (start_i) begin
      idx_q <= '0;
      if (load_tx_i) tx_q <= wdata_i;
    end else if (advance_i && !last_o) begin
      idx_q <= idx_q + 1'b1;
      tx_q  <= {1'b0, tx_q[DATA_W-1:1]};
    end
  end

  // LSB first: new bit enters at the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {sd_i, rx_q[DATA_W-1:1]};
  end

  assign sd_o      = tx_q[0];
  assign last_o    = (idx_q == LAST_IDX);
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/sser_regs.sv
module sser_regs
  import sser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              set_tx_done_i,
  input  logic              set_rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] rxbuf_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d, rxbuf_q;

  // hardware set wins over a same-cycle software write
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl_i)     ctrl_d = wdata_i;
    if (set_tx_done_i) ctrl_d[BIT_TXDONE] = 1'b1;
    if (set_rx_done_i) ctrl_d[BIT_RXDONE] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rxbuf_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (set_rx_done_i) rxbuf_q <= rx_byte_i;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rxbuf_o = rxbuf_q;
endmodule

// File: rtl/sser_mode0.sv
module sser_mode0
  import sser_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic              sd_i
);
  logic [DATA_W-1:0] ctrl_w, rxbuf_w, rx_byte_w;
  logic wr_ctrl, wr_data, mode_ok;
  logic start_tx, start_rx, start, done;
  logic sclk_low, sample, bit_end, last_bit, tx_bit;
  logic busy_q;
  dir_e dir_q;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_data = wr_en_i && (addr_i == ADDR_DATA);
  assign mode_ok = !ctrl_w[BIT_M0] && !ctrl_w[BIT_M1];

  assign start_tx = wr_data && !busy_q && mode_ok;
  assign start_rx = !wr_data && !busy_q && mode_ok &&
                    ctrl_w[BIT_RXEN] && !ctrl_w[BIT_RXDONE];
  assign start    = start_tx || start_rx;
  assign done     = bit_end && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= DIR_TX;
    end else if (start) begin
      busy_q <= 1'b1;
      dir_q  <= start_tx ? DIR_TX : DIR_RX;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  sser_bit_timer #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .fast_i     (ctrl_w[BIT_FAST]),
    .run_i      (busy_q),
    .sclk_low_o (sclk_low),
    .sample_o   (sample),
    .bit_end_o  (bit_end)
  );

  sser_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .load_tx_i (start_tx),
    .wdata_i   (wdata_i),
    .advance_i (bit_end),
    .sample_i  (sample && (dir_q == DIR_RX)),
    .sd_i      (sd_i),
    .sd_o      (tx_bit),
    .last_o    (last_bit),
    .rx_byte_o (rx_byte_w)
  );

  sser_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_ctrl_i     (wr_ctrl),
    .wdata_i       (wdata_i),
    .set_tx_done_i (done && (dir_q == DIR_TX)),
    .set_rx_done_i (done && (dir_q == DIR_RX)),
    .rx_byte_i     (rx_byte_w),
    .ctrl_o        (ctrl_w),
    .rxbuf_o       (rxbuf_w)
  );

  assign rdata_o = (addr_i == ADDR_DATA) ? rxbuf_w : ctrl_w;
  assign sclk_o  = !sclk_low;
  assign sd_oe_o = busy_q && (dir_q == DIR_TX);
  assign sd_o    = tx_bit;
endmodule

// File: rtl/sser_mode0_chk.sv
module sser_mode0_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       addr_i,
  input logic       sclk_o,
  input logic       sd_o,
  input logic       sd_oe_o,
  input logic       busy,
  input logic       dir_rx,
  input logic [7:0] ctrl
);
  p_idle_rest_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sclk_o && !sd_oe_o));

  p_mode_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && (ctrl[7:6] != 2'b00)) |=> !busy);

  p_bit_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o && $rose(sclk_o)) |-> $stable(sd_o));

  p_tx_done_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl[1]) && !$past(wr_en_i && !addr_i)) |-> $fell(sd_oe_o));

  p_rx_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && dir_rx) |-> !sd_oe_o);

  p_rx_done_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl[0]) && !$past(wr_en_i && !addr_i)) |-> (!busy && $past(busy)));

  p_ninth_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && !addr_i) |-> $stable(ctrl[3:2]));
endmodule

bind sser_mode0 sser_mode0_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .sclk_o  (sclk_o),
  .sd_o    (sd_o),
  .sd_oe_o (sd_oe_o),
  .busy    (busy_q),
  .dir_rx  (dir_q == sser_pkg::DIR_RX),
  .ctrl    (ctrl_w)
);

// File: tb/sser_mode0_test.sv
`timescale 1ns/1ps
module sser_mode0_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sclk, sd_out, sd_oe;
  logic       sd_in = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [7:0] last_rx = '0;

  always #2.5 clk = ~clk;

  sser_mode0 uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .sd_o(sd_out),
    .sd_oe_o(sd_oe), .sd_i(sd_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc();
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic tx_run(input logic [7:0] b, input bit fast, input bit inject);
    int p = fast ? 4 : 12;
    int nr = 0, lowrun = 0, badlow = 0, oe_bad = 0;
    logic prev = 1'b0;
    logic [7:0] got = '0;
    wr(1'b0, {2'b00, fast, 5'b0});
    wr(1'b1, b);
    prev = sclk;
    if (!sclk) lowrun = 1;
    for (int c = 1; c <= 8 * p; c++) begin
      if (inject && c == 3 * p) begin wr_en = 1'b1; addr = 1'b1; wdata = ~b; end
      cyc();
      if (inject && c == 3 * p) begin wr_en = 1'b0; addr = 1'b0; end
      if (c < 8 * p && !sd_oe) oe_bad++;
      if (!sclk) lowrun++;
      else begin
        if (!prev) begin
          if (lowrun != p / 2) badlow++;
          if (nr < 8) got[nr] = sd_out;
          nr++;
        end
        lowrun = 0;
      end
      prev = sclk;
      if (c == 8 * p - 1) chk("R5 tx done early", int'(rdata[1]), 0);
      if (c == 8 * p)     chk("R5 tx done due", int'(rdata[1]), 1);
    end
    chk("R4 tx byte LSB first", got, b);
    chk("R3 tx clock rises", nr, 8);
    chk("R3 low half length", badlow, 0);
    chk("R4 output enable", oe_bad, 0);
    addr = 1'b1;
    #1 chk("R11 read buffer kept", rdata, last_rx);
    addr = 1'b0;
    for (int c = 0; c < 2 * p; c++) begin
      cyc();
      if (!sclk || sd_oe) oe_bad++;
    end
    chk("R9 no second transfer", oe_bad, 0);
    chk("R5 tx done held", rdata, {2'b00, fast, 5'b00010});
    wr(1'b0, 8'h00);
    chk("R5 tx done cleared", int'(rdata[1]), 0);
  endtask

  task automatic rx_run(input logic [7:0] b, input bit fast, input bit inject);
    int p = fast ? 4 : 12;
    int nf = 0, oe_bad = 0, idle_bad = 0;
    logic prev = 1'b1;
    wr(1'b0, {2'b00, fast, 5'b11100});
    prev = sclk;
    for (int c = 1; c <= 8 * p + 1; c++) begin
      if (inject && c == 2 * p) begin wr_en = 1'b1; addr = 1'b1; wdata = ~b; end
      cyc();
      if (inject && c == 2 * p) begin wr_en = 1'b0; addr = 1'b0; end
      if (sd_oe) oe_bad++;
      if (!sclk && prev) begin
        if (nf < 8) sd_in = b[nf];
        nf++;
      end
      prev = sclk;
      if (c == 8 * p)     chk("R8 rx done early", int'(rdata[0]), 0);
      if (c == 8 * p + 1) chk("R8 rx done due", int'(rdata[0]), 1);
    end
    chk("R6 rx no drive", oe_bad, 0);
    chk("R6 rx clock falls", nf, 8);
    addr = 1'b1;
    #1 chk("R7 received byte", rdata, b);
    addr = 1'b0;
    last_rx = b;
    #1 chk("R10 ninth bits kept", rdata, {2'b00, fast, 5'b11101});
    for (int c = 0; c < 2 * p; c++) begin
      cyc();
      if (!sclk || sd_oe) idle_bad++;
    end
    chk("R8 no restart while done", idle_bad, 0);
    if (inject) chk("R9 write ignored in rx", idle_bad, 0);
    wr(1'b0, 8'h00);
  endtask

  initial begin
    logic [7:0] pats[6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk("R1 ctrl reset", rdata, 0);
    chk("R1 sclk idle", int'(sclk), 1);
    chk("R1 oe idle", int'(sd_oe), 0);
    addr = 1'b1;
    #1 chk("R1 rx buffer reset", rdata, 0);
    addr = 1'b0;

    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 6; i++) begin
        tx_run(pats[i], f[0], i == 2);
        rx_run(pats[i] ^ 8'(i * 37 + f), f[0], i == 3);
      end
    end

    begin
      int bad = 0;
      wr(1'b0, 8'h40);
      wr(1'b1, 8'h3C);
      for (int c = 0; c < 30; c++) begin
        cyc();
        if (!sclk || sd_oe) bad++;
      end
      wr(1'b0, 8'h90);
      for (int c = 0; c < 30; c++) begin
        cyc();
        if (!sclk || sd_oe) bad++;
      end
      chk("R2 other mode idle", bad, 0);
      chk("R2 no flags", rdata, 8'h90);
      addr = 1'b1;
      #1 chk("R11 buffer after blocked write", rdata, last_rx);
      addr = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule